// File: doc/BRIEF.md
# Interlaced Vertical Field Sequencer

This block produces the vertical timing of an interlaced raster display. It runs on a scan-line strobe from the horizontal timing. Each field has three phases. The first is vertical sync. The second is one extra blanked line, inserted only on odd fields to absorb the half-line offset of interlace. The third is the visible area, which includes the top and bottom borders. The outputs are the sync and blanking levels, a field-parity flag and three single-cycle event pulses. The pulses mark the end of the top border, the end of the field and a field-start interrupt.

The three line counts are sync length, top-border length and visible length (borders included), all in lines of the even field. Software writes them through a small register port. Each field latches the written values when it starts, so a write made during a field changes nothing until the next field boundary. The interrupt follows the latch, so software handling it can rewrite the counts without a race. After reset the block idles with blanking asserted until the first strobe arrives.

Top module: `vfield_seq`

## Requirements
- R1: After reset, and until the first `line_strobe`, `vsync` is 0, `vblank` is 1, `field_odd` is 1 and `field_irq`, `field_end` and `top_border_done` are 0. The first strobe starts a field.
- R2: A field starts on a strobe. From the following cycle `vsync` and `vblank` are both 1, and they stay so for exactly the programmed sync count of line periods, counting the start strobe as the first.
- R3: On an odd field (`field_odd`=1), the strobe that ends sync begins exactly one line with `vsync`=0 and `vblank`=1. On an even field that strobe goes directly to the visible area.
- R4: In the visible area `vsync` and `vblank` are both 0 for exactly the programmed visible count of lines. Border lines are part of this area.
- R5: `top_border_done` pulses for one cycle after the strobe that ends visible line number N, where N is the top-border count. If N exceeds the visible count it never pulses in that field.
- R6: `field_end` pulses for one cycle after the strobe that ends the last visible line. That same strobe starts the next field.
- R7: `field_irq` is a one-cycle pulse. It comes two cycles after every field-start strobe, that is, one cycle after the new field's counts have been latched.
- R8: When `cfg_we`=1, `cfg_sel` picks the count that `cfg_wdata` writes: 0 = sync, 1 = top border, 2 = visible. Code 3 writes nothing. A written value applies from the next field start onwards, never to the field in progress.
- R9: A written value of 0 is stored as 1, so every phase lasts at least one line.
- R10: `field_odd` flips at every field start, so successive fields alternate even and odd. The first field after reset is even.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| line_strobe | input | 1 | One-cycle pulse at each scan-line boundary |
| cfg_we | input | 1 | Count write enable |
| cfg_sel | input | 2 | Count select: 0 sync, 1 top border, 2 visible, 3 none |
| cfg_wdata | input | CNT_W | Line count to write |
| vsync | output | 1 | Vertical sync level |
| vblank | output | 1 | Vertical blanking level |
| field_odd | output | 1 | Parity of the current field (1 = odd) |
| top_border_done | output | 1 | One-cycle pulse at the end of the top border |
| field_end | output | 1 | One-cycle pulse at the end of the visible area |
| field_irq | output | 1 | One-cycle field-start interrupt |

## Verification
The assertions take for granted that `line_strobe` is a single-cycle pulse. They also assume that at least two clock cycles pass between strobes, so that every event pulse and the interrupt fall back to zero before the next line boundary. The stimulus drives each strobe for one cycle and leaves two idle cycles after it. Count writes are made only between strobes. The bench measures every phase length by counting strobes on both parities. It covers the clamp to one and a top border longer than the visible area.

// File: rtl/vfs_pkg.sv
// Shared types for the vertical field sequencer.
// Assumes: nothing beyond IEEE 1800-2017.
package vfs_pkg;

    // Vertical phase of the current field
    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_SYNC  = 2'd1,
        PH_EXTRA = 2'd2,
        PH_VIS   = 2'd3
    } vfs_phase_e;

    // Register select codes of the count port
    localparam logic [1:0] SEL_SYNC = 2'd0;
    localparam logic [1:0] SEL_TOP  = 2'd1;
    localparam logic [1:0] SEL_VIS  = 2'd2;

    localparam int NUM_CNT = 3;

endpackage

// File: rtl/vfs_cfg_regs.sv
// Count registers of the field sequencer: one written copy per count,
// plus per-field shadows of the top-border and visible counts.
// Assumes: latch pulses on a field-start strobe; a write of zero is
// stored as one.
module vfs_cfg_regs #(
    parameter int CNT_W    = 11,
    parameter int SYNC_DEF = 3,
    parameter int TOP_DEF  = 20,
    parameter int VIS_DEF  = 480
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [1:0]       cfg_sel,
    input  logic [CNT_W-1:0] cfg_wdata,
    input  logic             latch,
    output logic [CNT_W-1:0] prog_sync,
    output logic [CNT_W-1:0] act_top,
    output logic [CNT_W-1:0] act_vis
);
    import vfs_pkg::*;

    logic [CNT_W-1:0] prog_q [NUM_CNT];
    logic [CNT_W-1:0] wr_val;

    // Clamp a zero write to one line
    always_comb begin
        wr_val = (cfg_wdata == '0) ? CNT_W'(1) : cfg_wdata;
    end

    for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
        localparam int DEF = (i == 0) ? SYNC_DEF : ((i == 1) ? TOP_DEF : VIS_DEF);
        // Hold the written value of count i
        always_ff @(posedge clk) begin
            if (!rst_n)
                prog_q[i] <= CNT_W'(DEF);
            else if (cfg_we && (cfg_sel == 2'(i)))
                prog_q[i] <= wr_val;
        end

        // R9
        cnt_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
            prog_q[i] != '0);
    end

    // Freeze the counts used later in the field at its start
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_top <= CNT_W'(TOP_DEF);
            act_vis <= CNT_W'(VIS_DEF);
        end else if (latch) begin
            act_top <= prog_q[SEL_TOP];
            act_vis <= prog_q[SEL_VIS];
        end
    end

    assign prog_sync = prog_q[SEL_SYNC];

    // R8
    shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !latch |=> $stable(act_vis) && $stable(act_top));

endmodule

// File: rtl/vfs_down_counter.sv
// Loadable down counter with a zero flag.
// Assumes: the controller never decrements at zero.
module vfs_down_counter #(
    parameter int W = 11
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         dec,
    output logic [W-1:0] cnt,
    output logic         zero
);
    // Load takes priority over decrement
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (dec)
            cnt <= cnt - W'(1);
    end

    assign zero = (cnt == '0);

    // R4
    no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dec && !load) |-> (cnt != '0));

endmodule

// File: rtl/vfs_phase_fsm.sv
// Phase controller: steps sync -> (extra blank line on odd fields) ->
// visible on each line strobe, tracks field parity and raises the
// field-end, top-border and interrupt pulses.
// Assumes: line_strobe is one cycle wide with at least two idle cycles
// between strobes; counts are at least one.
module vfs_phase_fsm #(
    parameter int CNT_W = 11
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                line_strobe,
    input  logic [CNT_W-1:0]    prog_sync,
    input  logic [CNT_W-1:0]    act_top,
    input  logic [CNT_W-1:0]    act_vis,
    input  logic                lc_zero,
    input  logic                tc_zero,
    output logic                lc_load,
    output logic [CNT_W-1:0]    lc_val,
    output logic                lc_dec,
    output logic                tc_load,
    output logic [CNT_W-1:0]    tc_val,
    output logic                tc_dec,
    output logic                start_field,
    output vfs_pkg::vfs_phase_e phase,
    output logic                field_odd,
    output logic                top_border_done,
    output logic                field_end,
    output logic                field_irq
);
    import vfs_pkg::*;

    vfs_phase_e phase_q, phase_d;
    logic       armed_q;
    logic       enter_vis, top_hit, end_hit;
    logic       start_q;

    // Next-phase and counter-control decode on each strobe
    always_comb begin
        phase_d     = phase_q;
        start_field = 1'b0;
        enter_vis   = 1'b0;
        top_hit     = 1'b0;
        end_hit     = 1'b0;
        lc_load     = 1'b0;
        lc_val      = '0;
        lc_dec      = 1'b0;
        tc_load     = 1'b0;
        tc_val      = '0;
        tc_dec      = 1'b0;
        if (line_strobe) begin
            case (phase_q)
                PH_IDLE:  start_field = 1'b1;
                PH_SYNC: begin
                    if (!lc_zero)
                        lc_dec = 1'b1;
                    else if (field_odd)
                        phase_d = PH_EXTRA;
                    else
                        enter_vis = 1'b1;
                end
                PH_EXTRA: enter_vis = 1'b1;
                PH_VIS: begin
                    if (armed_q) begin
                        if (tc_zero) top_hit = 1'b1;
                        else         tc_dec  = 1'b1;
                    end
                    if (lc_zero) begin
                        end_hit     = 1'b1;
                        start_field = 1'b1;
                    end else begin
                        lc_dec = 1'b1;
                    end
                end
                default: phase_d = PH_IDLE;
            endcase
        end
        if (start_field) begin
            phase_d = PH_SYNC;
            lc_load = 1'b1;
            lc_dec  = 1'b0;
            lc_val  = prog_sync - CNT_W'(1);
        end
        if (enter_vis) begin
            phase_d = PH_VIS;
            lc_load = 1'b1;
            lc_val  = act_vis - CNT_W'(1);
            tc_load = 1'b1;
            tc_val  = act_top - CNT_W'(1);
        end
    end

    // Phase, parity and top-border arm state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q   <= PH_IDLE;
            field_odd <= 1'b1;
            armed_q   <= 1'b0;
        end else begin
            phase_q <= phase_d;
            if (start_field)
                field_odd <= ~field_odd;
            if (enter_vis)
                armed_q <= 1'b1;
            else if (top_hit || start_field)
                armed_q <= 1'b0;
        end
    end

    // Event pulses; the interrupt trails the count latch by one cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            top_border_done <= 1'b0;
            field_end       <= 1'b0;
            start_q         <= 1'b0;
            field_irq       <= 1'b0;
        end else begin
            top_border_done <= top_hit;
            field_end       <= end_hit;
            start_q         <= start_field;
            field_irq       <= start_q;
        end
    end

    assign phase = phase_q;

    // R3
    extra_only_odd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_EXTRA) |-> field_odd);

    // R3
    extra_one_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_EXTRA && line_strobe) |=> (phase_q == PH_VIS));

    // R10
    parity_at_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (field_odd != $past(field_odd)) |-> (phase_q == PH_SYNC));

    // R7
    irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        field_irq |=> !field_irq);

    // R7
    irq_after_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        field_end |=> field_irq);

    // R5
    top_in_visible_chk: assert property (@(posedge clk) disable iff (!rst_n)
        top_border_done |-> ($past(phase_q) == PH_VIS));

endmodule

// File: rtl/vfield_seq.sv
// Interlaced vertical field sequencer top: count registers, phase
// controller and two line counters (phase length and top border).
// Assumes: line_strobe pulses one cycle per scan line with at least two
// idle cycles between pulses.
module vfield_seq #(
    parameter int CNT_W    = 11,
    parameter int SYNC_DEF = 3,
    parameter int TOP_DEF  = 20,
    parameter int VIS_DEF  = 480
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             line_strobe,
    input  logic             cfg_we,
    input  logic [1:0]       cfg_sel,
    input  logic [CNT_W-1:0] cfg_wdata,
    output logic             vsync,
    output logic             vblank,
    output logic             field_odd,
    output logic             top_border_done,
    output logic             field_end,
    output logic             field_irq
);
    import vfs_pkg::*;

    logic [CNT_W-1:0] prog_sync, act_top, act_vis;
    logic             lc_load, lc_dec, lc_zero;
    logic             tc_load, tc_dec, tc_zero;
    logic [CNT_W-1:0] lc_val, tc_val, lc_cnt, tc_cnt;
    logic             start_field;
    vfs_phase_e       phase;

    vfs_cfg_regs #(
        .CNT_W(CNT_W), .SYNC_DEF(SYNC_DEF), .TOP_DEF(TOP_DEF), .VIS_DEF(VIS_DEF)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .latch(start_field),
        .prog_sync(prog_sync), .act_top(act_top), .act_vis(act_vis)
    );

    vfs_down_counter #(.W(CNT_W)) u_line_cnt (
        .clk(clk), .rst_n(rst_n),
        .load(lc_load), .load_val(lc_val), .dec(lc_dec),
        .cnt(lc_cnt), .zero(lc_zero)
    );

    vfs_down_counter #(.W(CNT_W)) u_top_cnt (
        .clk(clk), .rst_n(rst_n),
        .load(tc_load), .load_val(tc_val), .dec(tc_dec),
        .cnt(tc_cnt), .zero(tc_zero)
    );

    vfs_phase_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .line_strobe(line_strobe),
        .prog_sync(prog_sync), .act_top(act_top), .act_vis(act_vis),
        .lc_zero(lc_zero), .tc_zero(tc_zero),
        .lc_load(lc_load), .lc_val(lc_val), .lc_dec(lc_dec),
        .tc_load(tc_load), .tc_val(tc_val), .tc_dec(tc_dec),
        .start_field(start_field), .phase(phase), .field_odd(field_odd),
        .top_border_done(top_border_done), .field_end(field_end),
        .field_irq(field_irq)
    );

    // Decode the sync and blanking levels from the phase
    always_comb begin
        vsync  = (phase == PH_SYNC);
        vblank = (phase != PH_VIS);
    end

    // R2
    sync_in_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(vsync)) |-> $past(line_strobe));

    // R6
    end_starts_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
        field_end |-> (vsync && vblank));

    // R4
    line_cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_VIS) |-> (lc_cnt < act_vis));

    // R5
    top_cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_VIS) |-> (tc_cnt < act_top));

endmodule

// File: tb/vfield_seq_test.sv
// Self-checking bench: measures each phase length in lines on fields of
// both parities for a table of count settings, then directed checks.
module vfield_seq_test;

    localparam int CNT_W = 11;
    localparam int ROWS  = 5;
    // written sync, top, visible ; expected sync, top-done line (0 = none), visible
    localparam int TBL [ROWS][6] = '{
        '{3, 2, 6, 3, 2, 6},
        '{1, 1, 1, 1, 1, 1},
        '{0, 0, 4, 1, 1, 4},
        '{2, 5, 3, 2, 0, 3},
        '{4, 6, 9, 4, 6, 9}
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             line_strobe = 1'b0;
    logic             cfg_we = 1'b0;
    logic [1:0]       cfg_sel = 2'd0;
    logic [CNT_W-1:0] cfg_wdata = '0;
    logic vsync, vblank, field_odd, top_border_done, field_end, field_irq;

    int checks = 0;
    int errors = 0;
    logic c_vs, c_vb, c_odd, c_td, c_fe, c_irq0, c_irq, c_td2, c_fe2;
    logic exp_odd = 1'b1;

    vfield_seq #(.CNT_W(CNT_W), .SYNC_DEF(2), .TOP_DEF(3), .VIS_DEF(8)) uut (
        .clk(clk), .rst_n(rst_n), .line_strobe(line_strobe),
        .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .vsync(vsync), .vblank(vblank), .field_odd(field_odd),
        .top_border_done(top_border_done), .field_end(field_end),
        .field_irq(field_irq)
    );

    always #4 clk = ~clk;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // One strobe, then capture outputs over the two following cycles
    task automatic strobe();
        @(negedge clk) line_strobe = 1'b1;
        @(negedge clk) line_strobe = 1'b0;
        c_vs = vsync; c_vb = vblank; c_odd = field_odd;
        c_td = top_border_done; c_fe = field_end; c_irq0 = field_irq;
        @(negedge clk);
        c_irq = field_irq; c_td2 = top_border_done; c_fe2 = field_end;
    endtask

    task automatic write_cfg(input logic [1:0] sel, input int val);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = CNT_W'(val);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // Entered right after a field-start strobe; returns after the next one
    task automatic measure_field(input int es, input int et, input int ev, input string tag);
        int n;
        int extra;
        int lines;
        int top_at;
        int vis_bad;
        exp_odd = ~exp_odd;
        chk(c_vs && c_vb, {"R2 start levels ", tag}, {c_vs, c_vb}, 3);
        chk(c_odd == exp_odd, {"R10 parity ", tag}, c_odd, exp_odd);
        chk(!c_irq0 && c_irq, {"R7 irq timing ", tag}, {c_irq0, c_irq}, 1);
        n = 1;
        for (int g = 0; g < 300; g++) begin
            strobe();
            if (!c_vs) break;
            n++;
        end
        chk(n == es, {"R2 sync lines ", tag}, n, es);
        extra = 0;
        if (c_vb) begin
            extra = 1;
            strobe();
        end
        chk(extra == int'(exp_odd), {"R3 extra line ", tag}, extra, int'(exp_odd));
        chk(!c_vs && !c_vb, {"R4 visible levels ", tag}, {c_vs, c_vb}, 0);
        lines = 1; top_at = 0; vis_bad = 0;
        for (int g = 0; g < 300; g++) begin
            strobe();
            if (c_td && top_at == 0) top_at = lines;
            if (c_td2 || c_fe2) vis_bad++;
            if (c_fe) break;
            if (c_vb || c_vs) vis_bad++;
            lines++;
        end
        chk(lines == ev, {"R4 visible lines ", tag}, lines, ev);
        chk(top_at == et, {"R5 top border line ", tag}, top_at, et);
        chk(vis_bad == 0, {"R5 R6 one-cycle pulses ", tag}, vis_bad, 0);
        chk(c_fe && c_vs && c_vb, {"R6 end starts field ", tag}, {c_fe, c_vs, c_vb}, 7);
    endtask

    // Watchdog: a hung run ends as a failure
    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int ps, pt, pv;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        // R1: idle state after reset, no strobe yet
        repeat (5) @(negedge clk);
        chk(!vsync && vblank && field_odd, "R1 reset levels", {vsync, vblank, field_odd}, 3);
        chk(!field_irq && !field_end && !top_border_done, "R1 no pulses",
            {field_irq, field_end, top_border_done}, 0);
        strobe();
        chk(c_odd == 1'b0, "R1 R10 first field even", c_odd, 0);
        ps = 2; pt = 3; pv = 8;
        for (int r = 0; r < ROWS; r++) begin
            // R8: written mid-field, must not affect the current field
            write_cfg(2'd0, TBL[r][0]);
            write_cfg(2'd1, TBL[r][1]);
            write_cfg(2'd2, TBL[r][2]);
            measure_field(ps, pt, pv, $sformatf("row %0d old counts (R8)", r));
            // R8: select code 3 writes nothing
            write_cfg(2'd3, 0);
            measure_field(TBL[r][3], TBL[r][4], TBL[r][5], $sformatf("row %0d new (R9)", r));
            measure_field(TBL[r][3], TBL[r][4], TBL[r][5], $sformatf("row %0d repeat", r));
            ps = TBL[r][3]; pt = TBL[r][4]; pv = TBL[r][5];
        end
        // R1: reset in mid-field returns to idle
        @(negedge clk) rst_n = 1'b0;
        @(negedge clk) rst_n = 1'b1;
        @(negedge clk);
        chk(!vsync && vblank && field_odd && !field_irq, "R1 re-reset idle",
            {vsync, vblank, field_odd, field_irq}, 6);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule